// File: doc/BRIEF.md
# Exhaustive Input Pattern Scanner

This block walks a device under test through every combination of its inputs, one binary count per step, and stops on the first combination that pulls the device's active-low response line down. The operator reads the held pattern from the pattern output. The operator then raises a resume request to move one pattern past it and keep scanning. Steps are paced by a step-enable input rather than a free-running oscillator, so scanning can run at full clock rate or be throttled.

The count lives in a chain of fixed-width counter stages joined by carries. The pattern the device sees comes from a holding register that loads on the falling clock edge. The device inputs therefore change half a period away from the count update, and never on the same edge. The response passes through a two-flop synchronizer. A short history of presented patterns stays aligned with that synchronizer, so a halt reloads the counter with the exact pattern that caused the low response, however far the count had moved on. The top bit of the presented pattern is brought out as a sweep indicator.

Top module: `pattern_scanner`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high at a rising edge, the count clears. After the following falling edge, `pattern` is all zeros and `halted` is low.
- R2: The pattern advances by exactly one in ascending binary order on each rising edge where `stepEn` is high and the block is not halted. It does not change on an edge where `stepEn` is low.
- R3: After the all-ones pattern, the next step gives all zeros.
- R4: `msbInd` equals the most significant bit of `pattern`, so it makes one high and one low phase per full sweep of 2^PAT_W steps.
- R5: When `respN` is low for a presented pattern, the block halts within a few cycles, raises `halted`, and presents exactly that pattern. This holds whatever the rate of `stepEn`.
- R6: While halted, `pattern` stays constant whatever `stepEn` does.
- R7: A rising edge of `resumeReq` while halted clears `halted` and advances exactly one pattern at that edge. Holding `resumeReq` high causes no further advance.
- R8: After a resume, a low response still arriving for the pattern that was halted on does not halt the block again. The next pattern that drives `respN` low does halt it, including the pattern directly after the held one.
- R9: A `resumeReq` edge while not halted has no effect on `pattern`.
- R10: `pattern` changes only after the falling clock edge. Just after the rising edge that steps the count, it still shows the previous pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count updates on the rising edge and the pattern register on the falling edge |
| rst | input | 1 | Synchronous reset, active high |
| stepEn | input | 1 | Advance one pattern on this edge when not halted |
| respN | input | 1 | Active-low response from the device under test, asynchronous |
| resumeReq | input | 1 | Operator resume; its rising edge releases a halt |
| pattern | output | PAT_W | Registered pattern driven to the device inputs |
| halted | output | 1 | High while stepping is suspended by a response |
| msbInd | output | 1 | Most significant bit of the presented pattern |

## Verification
Free-running sweeps with no responding pattern separate correct increment, carry between stages and the wrap from all ones. Runs with random step density and a single random responding pattern show whether the halt lands on the causing pattern or on one of the patterns counted while the synchronizer was filling. Adjacent responding patterns, stale responses after a resume and resume held high tell a one-shot edge resume apart from a level-sensitive one, and from a resume that re-halts on its own history. A resume while running and sampling just after the rising edge confirm that resume has no effect outside a halt and that the pattern moves only on the falling edge.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Strobes sent from the scan control to the datapath
  typedef struct packed {
    logic step;    // advance the count by one
    logic reload;  // load the aligned pattern back into the count
  } scanCtrl_t;

endpackage

// File: rtl/scan_count_stage.sv
module scan_count_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= loadVal;
    end else if (inc) begin
      q <= q + 1'b1;
    end
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int PAT_W   = 20,
  parameter int STAGE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  scanCtrl_t        ctrl,
  input  logic             respN,
  output logic [PAT_W-1:0] patternOut,
  output logic             alignedLow,
  output logic [PAT_W-1:0] alignedPat
);

  localparam int NSTAGE = (PAT_W + STAGE_W - 1) / STAGE_W;

  logic [PAT_W-1:0]  count;
  logic [NSTAGE-1:0] carry;
  logic [1:0]        respSync;
  logic [PAT_W-1:0]  histA;
  logic [PAT_W-1:0]  histB;

  assign carry[0] = ctrl.step;

  // Cascaded counter stages; the last one takes whatever width is left
  for (genvar g = 0; g < NSTAGE; g++) begin : gStage
    localparam int LO = g * STAGE_W;
    localparam int SW = (LO + STAGE_W > PAT_W) ? (PAT_W - LO) : STAGE_W;

    scan_count_stage #(.W(SW)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .inc     (carry[g]),
      .load    (ctrl.reload),
      .loadVal (histB[LO +: SW]),
      .q       (count[LO +: SW])
    );

    if (g < NSTAGE - 1) begin : gCarry
      assign carry[g+1] = carry[g] & (&count[LO +: SW]);
    end
  end

  // Holding register loaded half a period after the count update
  always_ff @(negedge clk) begin
    if (rst) begin
      patternOut <= '0;
    end else begin
      patternOut <= count;
    end
  end

  // Two-flop synchronizer, flushed on reload so stale lows are dropped
  always_ff @(posedge clk) begin
    if (rst || ctrl.reload) begin
      respSync <= 2'b11;
    end else begin
      respSync <= {respSync[0], respN};
    end
  end

  // Pattern history kept in step with the synchronizer
  always_ff @(posedge clk) begin
    if (rst) begin
      histA <= '0;
      histB <= '0;
    end else if (ctrl.reload) begin
      histA <= histB;
      histB <= histB;
    end else begin
      histA <= patternOut;
      histB <= histA;
    end
  end

  assign alignedLow = ~respSync[1];
  assign alignedPat = histB;

endmodule

// File: rtl/scan_control.sv
module scan_control
  import scan_pkg::*;
#(
  parameter int PAT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stepEn,
  input  logic             resumeReq,
  input  logic             alignedLow,
  input  logic [PAT_W-1:0] alignedPat,
  output scanCtrl_t        ctrl,
  output logic             halted
);

  logic             resumePrev;
  logic             resumeRise;
  logic             skipValid;
  logic [PAT_W-1:0] skipPat;
  logic             skipHit;
  logic             haltCond;

  assign resumeRise = resumeReq & ~resumePrev;
  assign skipHit    = skipValid && (alignedPat == skipPat);
  assign haltCond   = !halted && alignedLow && !skipHit;

  always_comb begin
    ctrl        = '0;
    ctrl.reload = haltCond;
    ctrl.step   = (!halted && !haltCond && stepEn) || (halted && resumeRise);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resumePrev <= 1'b1;
    end else begin
      resumePrev <= resumeReq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= 1'b0;
    end else if (haltCond) begin
      halted <= 1'b1;
    end else if (halted && resumeRise) begin
      halted <= 1'b0;
    end
  end

  // Remember the halted pattern so its lingering response is ignored
  always_ff @(posedge clk) begin
    if (rst) begin
      skipValid <= 1'b0;
      skipPat   <= '0;
    end else if (haltCond) begin
      skipValid <= 1'b1;
      skipPat   <= alignedPat;
    end else if (!halted && skipValid && (alignedPat != skipPat)) begin
      skipValid <= 1'b0;
    end
  end

endmodule

// File: rtl/pattern_scanner.sv
module pattern_scanner
  import scan_pkg::*;
#(
  parameter int PAT_W   = 20,
  parameter int STAGE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stepEn,
  input  logic             respN,
  input  logic             resumeReq,
  output logic [PAT_W-1:0] pattern,
  output logic             halted,
  output logic             msbInd
);

  scanCtrl_t        ctrl;
  logic             alignedLow;
  logic [PAT_W-1:0] alignedPat;

  scan_control #(.PAT_W(PAT_W)) u_control (
    .clk        (clk),
    .rst        (rst),
    .stepEn     (stepEn),
    .resumeReq  (resumeReq),
    .alignedLow (alignedLow),
    .alignedPat (alignedPat),
    .ctrl       (ctrl),
    .halted     (halted)
  );

  scan_datapath #(.PAT_W(PAT_W), .STAGE_W(STAGE_W)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .respN      (respN),
    .patternOut (pattern),
    .alignedLow (alignedLow),
    .alignedPat (alignedPat)
  );

  assign msbInd = pattern[PAT_W-1];

endmodule

// File: rtl/pattern_scanner_chk.sv
module pattern_scanner_chk #(
  parameter int PAT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             respN,
  input logic             resumeReq,
  input logic [PAT_W-1:0] pattern,
  input logic             halted
);

  logic [PAT_W-1:0] prevPat;
  logic [PAT_W-1:0] incPat;
  logic             prevValid;

  always_ff @(posedge clk) begin
    prevPat   <= pattern;
    prevValid <= !rst;
  end

  assign incPat = prevPat + 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pattern == '0) && !halted); // R1

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    prevValid && !halted && (pattern != prevPat) |-> pattern == incPat); // R2

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> !respN); // R5

  AST_HOLD_WHILE_HALTED: assert property (@(posedge clk) disable iff (rst)
    prevValid && halted && $past(halted) |-> pattern == prevPat); // R6

  AST_RESUME_EDGE: assert property (@(posedge clk) disable iff (rst)
    $fell(halted) |-> $past(resumeReq) && !$past(resumeReq, 2)); // R7

  AST_RESUME_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    prevValid && $fell(halted) |-> pattern == incPat); // R7

endmodule

bind pattern_scanner pattern_scanner_chk #(.PAT_W(PAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .respN     (respN),
  .resumeReq (resumeReq),
  .pattern   (pattern),
  .halted    (halted)
);

// File: tb/pattern_scanner_bench.sv
`timescale 1ns/1ps
module pattern_scanner_bench;

  localparam int PW = 10;
  localparam int SW = 4;
  localparam int TOP = (1 << PW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stepEn = 1'b0;
  logic          resumeReq = 1'b0;
  logic          respN;
  logic [PW-1:0] pattern;
  logic          halted;
  logic          msbInd;

  logic [PW-1:0] tgt [4];
  logic [3:0]    tgtOn = 4'b0000;

  int checks = 0;
  int fails  = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  // Device model: pulls its response low on any enabled target pattern
  always_comb begin
    respN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (tgtOn[i] && pattern == tgt[i]) respN = 1'b0;
    end
  end

  pattern_scanner #(.PAT_W(PW), .STAGE_W(SW)) u_pattern_scanner (
    .clk       (clk),
    .rst       (rst),
    .stepEn    (stepEn),
    .respN     (respN),
    .resumeReq (resumeReq),
    .pattern   (pattern),
    .halted    (halted),
    .msbInd    (msbInd)
  );

  function automatic logic [PW-1:0] nextPat(input logic [PW-1:0] p);
    return p + 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic doReset();
    rst = 1'b1;
    stepEn = 1'b0;
    resumeReq = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic runToHalt(input int density, input int maxCyc);
    for (int i = 0; i < maxCyc && !halted; i++) begin
      stepEn = (($urandom % 100) < density);
      tick();
    end
    stepEn = 1'b0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
    $finish;
  end

  initial begin
    logic [PW-1:0] expPat;
    int mism;
    int edges;
    logic lastMsb;

    void'($urandom(32'd1234));
    tgt[0] = '0; tgt[1] = '0; tgt[2] = '0; tgt[3] = '0;

    // R1: reset state
    doReset();
    check(pattern == 0, "R1 pattern after reset", int'(pattern), 0);
    check(halted == 0, "R1 halted after reset", int'(halted), 0);
    check(msbInd == 0, "R1 msbInd after reset", int'(msbInd), 0);

    // R2: directed steps then idle
    for (int i = 0; i < 7; i++) begin
      stepEn = 1'b1; tick();
      stepEn = 1'b0; tick();
    end
    check(pattern == 7, "R2 seven single steps", int'(pattern), 7);
    repeat (6) tick();
    check(pattern == 7, "R2 no step with stepEn low", int'(pattern), 7);

    // R10: pattern moves only after the falling edge
    stepEn = 1'b1;
    @(posedge clk); #1;
    stepEn = 1'b0;
    check(pattern == 7, "R10 unchanged after rising edge", int'(pattern), 7);
    @(negedge clk); #1;
    check(pattern == 8, "R10 updated after falling edge", int'(pattern), 8);

    // R2: random step density, model tracked in the bench
    expPat = 8;
    mism = 0;
    for (int i = 0; i < 3000; i++) begin
      stepEn = (($urandom % 100) < 40);
      tick();
      if (stepEn) expPat = nextPat(expPat);
      if (pattern != expPat) mism++;
    end
    stepEn = 1'b0;
    check(mism == 0, "R2 random stepping mismatches", mism, 0);
    check(pattern == expPat, "R2 random stepping final", int'(pattern), int'(expPat));

    // R3 / R4: full sweep, wrap and indicator
    doReset();
    stepEn = 1'b1;
    edges = 0;
    lastMsb = 1'b0;
    for (int i = 0; i < TOP; i++) begin
      tick();
      if (msbInd != lastMsb) edges++;
      lastMsb = msbInd;
    end
    check(pattern == TOP, "R3 all ones reached", int'(pattern), TOP);
    check(msbInd == 1, "R4 msbInd high in upper half", int'(msbInd), 1);
    tick();
    stepEn = 1'b0;
    check(pattern == 0, "R3 wrap to zero", int'(pattern), 0);
    check(msbInd == 0, "R4 msbInd low after wrap", int'(msbInd), 0);
    if (msbInd != lastMsb) edges++;
    check(edges == 2, "R4 indicator edges per sweep", edges, 2);

    // R5 / R6: random single target, random density
    for (int r = 0; r < 5; r++) begin
      logic [PW-1:0] t;
      int dens;
      t = PW'(20 + ($urandom % 900));
      dens = 20 + int'($urandom % 81);
      doReset();
      tgt[0] = t; tgtOn = 4'b0001;
      runToHalt(dens, 20000);
      check(halted == 1, "R5 halted on target", int'(halted), 1);
      check(pattern == t, "R5 held pattern is the cause", int'(pattern), int'(t));
      stepEn = 1'b1;
      repeat (10) tick();
      stepEn = 1'b0;
      check(pattern == t, "R6 pattern frozen while halted", int'(pattern), int'(t));
      check(halted == 1, "R6 still halted with stepEn high", int'(halted), 1);
    end

    // R7 / R8: adjacent targets, held resume, stale response
    doReset();
    tgt[0] = 10'd50; tgt[1] = 10'd51; tgt[2] = 10'd60;
    tgtOn = 4'b0111;
    runToHalt(100, 2000);
    check(pattern == 50, "R5 first target", int'(pattern), 50);
    resumeReq = 1'b1;
    tick();
    check(pattern == 51, "R7 resume advances one", int'(pattern), 51);
    check(halted == 0, "R7 resume clears halted", int'(halted), 0);
    repeat (5) tick();
    check(halted == 1, "R8 adjacent target halts", int'(halted), 1);
    check(pattern == 51, "R8 adjacent target held", int'(pattern), 51);
    stepEn = 1'b1;
    repeat (5) tick();
    stepEn = 1'b0;
    check(pattern == 51, "R7 held resume gives no advance", int'(pattern), 51);
    resumeReq = 1'b0;
    tick();
    resumeReq = 1'b1;
    tick();
    resumeReq = 1'b0;
    check(pattern == 52, "R7 second resume advances one", int'(pattern), 52);
    repeat (5) tick();
    check(halted == 0, "R8 stale low does not re-halt", int'(halted), 0);
    check(pattern == 52, "R8 pattern kept without steps", int'(pattern), 52);
    runToHalt(100, 2000);
    check(pattern == 60, "R8 next target halts", int'(pattern), 60);
    tgtOn = 4'b0000;

    // R9: resume while scanning
    doReset();
    stepEn = 1'b1;
    repeat (5) tick();
    stepEn = 1'b0;
    resumeReq = 1'b1;
    repeat (3) tick();
    resumeReq = 1'b0;
    tick();
    check(pattern == 5, "R9 resume ignored when not halted", int'(pattern), 5);
    check(halted == 0, "R9 halted stays low", int'(halted), 0);

    report();
    $finish;
  end

endmodule